// File: doc/BRIEF.md
# Audio Subframe Word Builder

This block builds the 32-bit subframe words of a two-channel consumer digital audio link, one word per request from the downstream line encoder. For each request it picks the left or right sample, from either the raw decoder path or the path after concealment, mute and fade, and places it in the payload. It adds the channel's uncorrectable-error flag as the validity bit, one bit of the subcode user stream and one channel-status bit, then closes the word with even parity. It also emits a preamble code that tells the encoder which sync pattern to send.

The block keeps its own word position inside a block of 384 words, starting on a left word. Left and right words alternate, and each left/right pair carries one channel-status bit, so there are 192 status bits per block. The status sequence is fixed to the compact-disc category. Its first four bits are the checked subcode control bits, captured once at the start of every block. Two of its bits carry a clock-accuracy setting. The subcode user bits arrive over a valid/ready handshake that has no relation to the block timing. When no user bit is waiting, a zero is sent.

The raw path must be selected whenever the decoder runs a data-disc mode.

Top module: `subframe_builder`

## Requirements
- R1: In every output word, bits 27 down to 12 hold the chosen 16-bit two's-complement sample, with its LSB at bit 12. Bits 11 down to 0 are zero.
- R2: When `src_post` is 1 the sample comes from the post-concealment inputs. When it is 0 the sample comes from the pre-concealment inputs.
- R3: Bit 28 equals the error flag of the word's channel (`err_l` or `err_r`), whichever sample source is selected.
- R4: `ud_ready` is high exactly while a request is presented. Bit 29 is `ud_bit` when `ud_valid` is high at the request, and 0 otherwise.
- R5: Bit 30 is channel-status bit number floor(position/2). Position runs 0 to 383 within a block, so a left word and the right word that follows it carry the same status bit.
- R6: The status bit number i is `q_ctrl[i]` for i = 0 to 3, is 1 for i = 8, is `clk_acc[1]` for i = 28 and `clk_acc[0]` for i = 29, and is 0 for every other i.
- R7: `q_ctrl` is sampled only at the request for position 0. Later changes within the block do not affect status bits 0 to 3 of that block.
- R8: Bit 31 makes bits 31 down to 4 hold an even number of ones.
- R9: Position 0 is a left word. Even positions are left and odd positions are right, and the position wraps from 383 to 0. `sf_pre` is 0 for position 0, 1 for other left words and 2 for right words.
- R10: A request sampled at a rising edge gives `sf_valid` = 1, with the new word and preamble, after that edge. `sf_valid` is 0 after any edge without a request.
- R11: While reset is applied, `sf_valid`, `sf_word` and `sf_pre` are 0. After reset the first word is position 0 of a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| word_req | input | 1 | Request for the next subframe word |
| src_post | input | 1 | 1: post-concealment samples, 0: pre-concealment samples |
| pre_smp_l | input | 16 | Left sample before concealment |
| pre_smp_r | input | 16 | Right sample before concealment |
| post_smp_l | input | 16 | Left sample after concealment, mute and fade |
| post_smp_r | input | 16 | Right sample after concealment, mute and fade |
| err_l | input | 1 | Uncorrectable-error flag of the left sample |
| err_r | input | 1 | Uncorrectable-error flag of the right sample |
| q_ctrl | input | 4 | Checked subcode control bits |
| clk_acc | input | 2 | Clock-accuracy setting for status bits 28 and 29 |
| ud_bit | input | 1 | Subcode user data bit |
| ud_valid | input | 1 | A user bit is offered |
| ud_ready | output | 1 | The user bit is taken in this cycle |
| sf_valid | output | 1 | A new word is on `sf_word` |
| sf_word | output | 32 | Subframe word, bits 3 to 0 left zero for the preamble |
| sf_pre | output | 2 | Preamble select: 0 block start, 1 left, 2 right |

## Verification
The bench runs over three full blocks with a different sample source, clock-accuracy setting and control value in each. Requests come back to back and also with gaps, so a position counter that advances on idle cycles would misplace the preamble and status bits. The control input is changed right after word 0 of every block. A design that latches it continuously would send the new value in status bits 0 to 3. Extreme sample values and error flags on a post-concealment block catch a validity bit taken from the wrong source or channel. A reset partway through a block checks that the position restarts at a block start rather than carrying on from the old count.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned VAL_BIT = 28;
  localparam int unsigned USR_BIT = 29;
  localparam int unsigned CS_BIT  = 30;
  localparam int unsigned PAR_BIT = 31;
  localparam int unsigned PAR_LO  = 4;

  localparam int unsigned CAT_IDX = 8;
  localparam int unsigned ACC_IDX = 28;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_e;

endpackage

// File: rtl/sfb_pos_track.sv
module sfb_pos_track #(
  parameter  int unsigned BLOCK_WORDS = 384,
  localparam int unsigned POS_W       = $clog2(BLOCK_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [POS_W-1:0] pos_o,
  output logic             blk_start_o,
  output logic             right_o
);

  localparam logic [POS_W-1:0] LAST = POS_W'(BLOCK_WORDS - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    pos_d = pos_q;
    if (pos_q == LAST) begin
      pos_d = '0;
    end else begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (adv) begin
      pos_q <= pos_d;
    end
  end

  assign pos_o       = pos_q;
  assign blk_start_o = (pos_q == '0);
  assign right_o     = pos_q[0];

endmodule

// File: rtl/sfb_cstat_gen.sv
module sfb_cstat_gen
  import sfb_pkg::*;
#(
  parameter  int unsigned CS_LEN = 192,
  parameter  int unsigned CTRL_W = 4,
  localparam int unsigned IDX_W  = $clog2(CS_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              blk_start,
  input  logic [IDX_W-1:0]  cs_idx,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [1:0]        acc_i,
  output logic              cs_bit_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_eff;
  logic              ctrl_en;

  // capture once per block, on the request for word 0
  assign ctrl_en  = req & blk_start;
  assign ctrl_eff = blk_start ? ctrl_i : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_i;
    end
  end

  always_comb begin
    cs_bit_o = 1'b0;
    for (int k = 0; k < int'(CTRL_W); k++) begin
      if (cs_idx == IDX_W'(k)) begin
        cs_bit_o = ctrl_eff[k];
      end
    end
    if (cs_idx == IDX_W'(CAT_IDX)) begin
      cs_bit_o = 1'b1;
    end
    if (cs_idx == IDX_W'(ACC_IDX)) begin
      cs_bit_o = acc_i[1];
    end
    if (cs_idx == IDX_W'(ACC_IDX + 1)) begin
      cs_bit_o = acc_i[0];
    end
  end

endmodule

// File: rtl/sfb_payload.sv
module sfb_payload
  import sfb_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                err_i,
  input  logic                usr_i,
  input  logic                cs_i,
  output logic [WORD_W-1:0]   word_o
);

  logic [WORD_W-1:0] body;

  always_comb begin
    body                        = '0;
    body[VAL_BIT-1 -: SAMPLE_W] = smp_i;
    body[VAL_BIT]               = err_i;
    body[USR_BIT]               = usr_i;
    body[CS_BIT]                = cs_i;
    word_o                      = body;
    word_o[PAR_BIT]             = ^body[PAR_BIT-1:PAR_LO];
  end

endmodule

// File: rtl/subframe_builder.sv
module subframe_builder
  import sfb_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned BLOCK_WORDS = 384,
  parameter int unsigned CTRL_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_req,
  input  logic                src_post,
  input  logic [SAMPLE_W-1:0] pre_smp_l,
  input  logic [SAMPLE_W-1:0] pre_smp_r,
  input  logic [SAMPLE_W-1:0] post_smp_l,
  input  logic [SAMPLE_W-1:0] post_smp_r,
  input  logic                err_l,
  input  logic                err_r,
  input  logic [CTRL_W-1:0]   q_ctrl,
  input  logic [1:0]          clk_acc,
  input  logic                ud_bit,
  input  logic                ud_valid,
  output logic                ud_ready,
  output logic                sf_valid,
  output logic [WORD_W-1:0]   sf_word,
  output logic [1:0]          sf_pre
);

  localparam int unsigned POS_W  = $clog2(BLOCK_WORDS);
  localparam int unsigned CS_LEN = BLOCK_WORDS / 2;
  localparam int unsigned IDX_W  = $clog2(CS_LEN);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  logic             req;
  logic [POS_W-1:0] pos;
  logic             blk_start;
  logic             right;
  logic [IDX_W-1:0] cs_idx;

  assign req      = word_req & rst_core_n;
  assign ud_ready = req;

  sfb_pos_track #(
    .BLOCK_WORDS (BLOCK_WORDS)
  ) pos_i (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .adv         (req),
    .pos_o       (pos),
    .blk_start_o (blk_start),
    .right_o     (right)
  );

  assign cs_idx = pos[POS_W-1:1];

  logic cs_bit;

  sfb_cstat_gen #(
    .CS_LEN (CS_LEN),
    .CTRL_W (CTRL_W)
  ) cstat_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req       (req),
    .blk_start (blk_start),
    .cs_idx    (cs_idx),
    .ctrl_i    (q_ctrl),
    .acc_i     (clk_acc),
    .cs_bit_o  (cs_bit)
  );

  logic [SAMPLE_W-1:0] smp_l;
  logic [SAMPLE_W-1:0] smp_r;
  logic [SAMPLE_W-1:0] smp_sel;
  logic                err_sel;
  logic                usr_sel;

  always_comb begin
    smp_l   = src_post ? post_smp_l : pre_smp_l;
    smp_r   = src_post ? post_smp_r : pre_smp_r;
    smp_sel = right ? smp_r : smp_l;
    err_sel = right ? err_r : err_l;
    usr_sel = ud_valid & ud_bit;
  end

  logic [WORD_W-1:0] word_d;

  sfb_payload #(
    .SAMPLE_W (SAMPLE_W)
  ) pay_i (
    .smp_i  (smp_sel),
    .err_i  (err_sel),
    .usr_i  (usr_sel),
    .cs_i   (cs_bit),
    .word_o (word_d)
  );

  pre_e pre_d;
  pre_e pre_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  always_comb begin
    if (blk_start) begin
      pre_d = PRE_BLOCK;
    end else if (right) begin
      pre_d = PRE_RIGHT;
    end else begin
      pre_d = PRE_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      word_q <= '0;
      pre_q  <= PRE_BLOCK;
    end else if (req) begin
      word_q <= word_d;
      pre_q  <= pre_d;
    end
  end

  assign sf_valid = valid_q;
  assign sf_word  = word_q;
  assign sf_pre   = pre_q;

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter  int unsigned SAMPLE_W    = 16,
  parameter  int unsigned BLOCK_WORDS = 384,
  localparam int unsigned POS_W       = $clog2(BLOCK_WORDS)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        word_req,
  input logic        ud_valid,
  input logic        sf_valid,
  input logic [31:0] sf_word,
  input logic [1:0]  sf_pre
);

  localparam int unsigned    SMP_LSB = 28 - SAMPLE_W;
  localparam logic [POS_W-1:0] LAST  = POS_W'(BLOCK_WORDS - 1);

  logic [POS_W-1:0] cnt_q;
  logic             last_cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      last_cs_q <= 1'b0;
    end else if (sf_valid) begin
      cnt_q     <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      last_cs_q <= sf_word[30];
    end
  end

  // R10
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |=> sf_valid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_req |=> !sf_valid);

  // R8
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> (^sf_word[31:4]) == 1'b0);

  // R1
  low_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> sf_word[SMP_LSB-1:0] == '0);

  // R9
  block_start_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> ((sf_pre == 2'd0) == (cnt_q == '0)));

  // R9
  side_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> ((sf_pre == 2'd2) == cnt_q[0]));

  // R4
  user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !ud_valid) |=> !sf_word[29]);

  // R5
  cs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && cnt_q[0]) |-> sf_word[30] == last_cs_q);

endmodule

bind subframe_builder sfb_checker #(
  .SAMPLE_W    (SAMPLE_W),
  .BLOCK_WORDS (BLOCK_WORDS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .word_req (word_req),
  .ud_valid (ud_valid),
  .sf_valid (sf_valid),
  .sf_word  (sf_word),
  .sf_pre   (sf_pre)
);

// File: tb/subframe_builder_tb_top.sv
module subframe_builder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 16;
  localparam int BW         = 384;

  logic          clk;
  logic          rst_n;
  logic          word_req;
  logic          src_post;
  logic [SW-1:0] pre_smp_l;
  logic [SW-1:0] pre_smp_r;
  logic [SW-1:0] post_smp_l;
  logic [SW-1:0] post_smp_r;
  logic          err_l;
  logic          err_r;
  logic [3:0]    q_ctrl;
  logic [1:0]    clk_acc;
  logic          ud_bit;
  logic          ud_valid;
  logic          ud_ready;
  logic          sf_valid;
  logic [31:0]   sf_word;
  logic [1:0]    sf_pre;

  int total;
  int bad;

  subframe_builder #(
    .SAMPLE_W    (SW),
    .BLOCK_WORDS (BW),
    .CTRL_W      (4)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_req   (word_req),
    .src_post   (src_post),
    .pre_smp_l  (pre_smp_l),
    .pre_smp_r  (pre_smp_r),
    .post_smp_l (post_smp_l),
    .post_smp_r (post_smp_r),
    .err_l      (err_l),
    .err_r      (err_r),
    .q_ctrl     (q_ctrl),
    .clk_acc    (clk_acc),
    .ud_bit     (ud_bit),
    .ud_valid   (ud_valid),
    .ud_ready   (ud_ready),
    .sf_valid   (sf_valid),
    .sf_word    (sf_word),
    .sf_pre     (sf_pre)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_pre_l(int p, int b);
    if (p == 4) return 16'h8000;
    if (p == 6) return 16'h7FFF;
    return 16'(p * 421 + b * 977) ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] f_pre_r(int p, int b);
    return 16'(p * 613 + 33 + b);
  endfunction
  function automatic logic [15:0] f_post_l(int p, int b);
    if (p == 8) return 16'h8000;
    return 16'(p * 97 + b) ^ 16'hFFFF;
  endfunction
  function automatic logic [15:0] f_post_r(int p, int b);
    if (p == 9) return 16'h7FFF;
    return 16'(b * 4099 + p * 7);
  endfunction
  function automatic logic [3:0] f_q(int b);
    return 4'(b * 5 + 3);
  endfunction
  function automatic logic [1:0] f_acc(int b);
    case (b % 3)
      0:       return 2'b10;
      1:       return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
  function automatic logic f_cs(int p, int b);
    int i;
    logic [3:0] q;
    logic [1:0] a;
    i = p / 2;
    q = f_q(b);
    a = f_acc(b);
    if (i < 4) return q[i];
    if (i == 8) return 1'b1;
    if (i == 28) return a[1];
    if (i == 29) return a[0];
    return 1'b0;
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic send(input int p, input int b, input int gap);
    logic        left;
    logic        post;
    logic [15:0] smp;
    logic        err;
    logic        usr;
    logic        uv;
    logic        cs;
    logic        par;
    logic [1:0]  pre;
    logic [31:0] w;
    left       = (p % 2 == 0);
    post       = (b % 2 == 1);
    uv         = (p % 3 != 2);
    pre_smp_l  = f_pre_l(p, b);
    pre_smp_r  = f_pre_r(p, b);
    post_smp_l = f_post_l(p, b);
    post_smp_r = f_post_r(p, b);
    err_l      = (p % 7 == 3);
    err_r      = (p % 5 == 1) || (p == 9);
    src_post   = post;
    ud_valid   = uv;
    ud_bit     = ((p >> 1) & 1) != ((p >> 3) & 1);
    q_ctrl     = (p == 0) ? f_q(b) : ~f_q(b);
    clk_acc    = f_acc(b);
    word_req   = 1'b1;
    #1;
    check("R4", "ready during request", 32'(ud_ready), 32'd1);
    smp = left ? (post ? post_smp_l : pre_smp_l) : (post ? post_smp_r : pre_smp_r);
    err = left ? err_l : err_r;
    usr = uv & ud_bit;
    cs  = f_cs(p, b);
    w   = {1'b0, cs, usr, err, smp, 12'h000};
    par = ^w[30:4];
    pre = (p == 0) ? 2'd0 : (left ? 2'd1 : 2'd2);
    @(negedge clk);
    word_req = 1'b0;
    check("R10", "valid after request", 32'(sf_valid), 32'd1);
    check("R1/R2", "sample field", 32'(sf_word[27:12]), 32'(smp));
    check("R1", "low field", 32'(sf_word[11:0]), 32'd0);
    check("R3", "validity bit", 32'(sf_word[28]), 32'(err));
    check("R4", "user bit", 32'(sf_word[29]), 32'(usr));
    if (p >= 2 && p < 8)
      check("R7", "latched control in status", 32'(sf_word[30]), 32'(cs));
    else
      check("R5/R6", "status bit", 32'(sf_word[30]), 32'(cs));
    check("R8", "parity bit", 32'(sf_word[31]), 32'(par));
    check("R9", "preamble", 32'(sf_pre), 32'(pre));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R10", "idle valid", 32'(sf_valid), 32'd0);
    end
  endtask

  initial begin
    total      = 0;
    bad        = 0;
    rst_n      = 1'b0;
    word_req   = 1'b0;
    src_post   = 1'b0;
    pre_smp_l  = '0;
    pre_smp_r  = '0;
    post_smp_l = '0;
    post_smp_r = '0;
    err_l      = 1'b0;
    err_r      = 1'b0;
    q_ctrl     = '0;
    clk_acc    = '0;
    ud_bit     = 1'b0;
    ud_valid   = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "reset valid", 32'(sf_valid), 32'd0);
    check("R11", "reset word", sf_word, 32'd0);
    check("R11", "reset preamble", 32'(sf_pre), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int b = 0; b < 3; b++) begin
      for (int p = 0; p < BW; p++) begin
        send(p, b, (p % 4 == 1) ? 2 : ((p % 4 == 3) ? 1 : 0));
      end
    end

    for (int p = 0; p < 10; p++) send(p, 3, 0);
    rst_n = 1'b0;
    #1;
    check("R11", "mid-block reset valid", 32'(sf_valid), 32'd0);
    check("R11", "mid-block reset word", sf_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 12; p++) send(p, 4, p % 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule